// File: doc/BRIEF.md
# Scan Frequency Mode Controller

This block steers the clock system of a chip whose single PLL feeds four synchronous domains during at-speed scan test. The domains are the processor, the display, the system bus and the peripheral bus, ranked from fastest to slowest. On entry into test mode a two-bit mode code is taken from two pins. The block then drives three sets of controls: a PLL frequency code, one divider-bypass control per domain, and a clock-source select per domain. The clock-source select chooses between the functional clock, the controlled at-speed clock and the tester clock.

The modes are nested. Mode 0 sends the controlled clock to the processor domain only. Each higher mode adds the next slower domain and lowers the PLL rate to that domain's rate. A path between two participating domains is therefore always tested at the rate of the slowest one, and no domain ever receives a clock faster than it supports. The domains left out receive the tester clock. When test mode is left, every control returns to its functional value.

Top module: `scan_freq_ctrl`

## Requirements
- R1: While reset is asserted and after it is released with test enable low, every clock select is functional (00), the PLL code is 0, the divider bypass is 0, the active flag is 0 and the reported mode is 0.
- R2: The mode pins are captured at the first rising clock edge at which test enable is high. The outputs take the new mode at the following rising edge, so they remain functional for one cycle after that first edge.
- R3: While test mode stays active, later changes on the mode pins have no effect on any output.
- R4: Each domain has a 2-bit select field. Domain d sits at bits [2d+1:2d], with domain 0 the processor, 1 the display, 2 the system bus and 3 the peripheral bus. The codes are 00 functional, 01 controlled at-speed clock and 10 tester clock. Code 11 never appears.
- R5: In test mode m (pins 00, 01, 10, 11 give m = 0..3), domains 0..m select the at-speed clock and all higher domains select the tester clock. This gives clk_sel values 0xA9, 0xA5, 0x95 and 0x55.
- R6: The PLL code is 0 for the functional 800 MHz setting. In test modes 0..3 it is 1..4, meaning 400, 266, 133 and 66 MHz.
- R7: In test mode every divider-bypass bit is 1, which forces divide-by-one. In functional mode every bit is 0, which leaves the normal dividers in use.
- R8: After test enable falls, all outputs return to their functional values on the second rising edge. A later entry captures the pins afresh.
- R9: The mode output reports the captured mode while the active flag is high. The number of domains on the at-speed clock always equals that mode plus one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| test_en_i | input | 1 | Scan test mode enable |
| mode_pins_i | input | 2 | Scan frequency mode code pins |
| pll_sel_o | output | 3 | PLL frequency code (0 functional, 1..4 test rates) |
| div_bypass_o | output | 4 | Per-domain divide-by-one force |
| clk_sel_o | output | 8 | Per-domain 2-bit clock source select |
| test_active_o | output | 1 | Test mode captured and applied |
| mode_o | output | 2 | Currently applied mode |

## Verification
The condition hardest to reach from the ports is a change on the mode pins after the mode has been captured, in the middle of a pattern set. In that case the outputs must stay frozen. The stimulus enters each mode, checks the one-cycle latency window, and then drives the inverted code onto the pins for several cycles before checking again. It also leaves test mode and re-enters it with a different code, and it applies reset while test mode is active.

// File: rtl/scan_freq_pkg.sv
// Shared encodings for the scan frequency mode controller.
// Assumes domain index 0 is the fastest domain and higher indices are slower.
package scan_freq_pkg;
    typedef enum logic [1:0] {
        SRC_FUNC    = 2'b00,
        SRC_ATSPEED = 2'b01,
        SRC_TESTER  = 2'b10
    } clk_src_e;

    localparam int PLL_CODE_FUNC = 0;
endpackage

// File: rtl/scan_mode_capture.sv
// Captures the mode pins on entry to test mode and holds them for the whole
// pattern set. Assumes test enable is quasi-static relative to clk.
module scan_mode_capture #(
    parameter int MODE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              test_en_i,
    input  logic [MODE_W-1:0] mode_pins_i,
    output logic              active_o,
    output logic [MODE_W-1:0] mode_o
);
    // Purpose: load the code once on entry, clear it on exit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_o <= 1'b0;
            mode_o   <= '0;
        end else if (!test_en_i) begin
            active_o <= 1'b0;
            mode_o   <= '0;
        end else if (!active_o) begin
            active_o <= 1'b1;
            mode_o   <= mode_pins_i;
        end
    end
endmodule

// File: rtl/domain_sel_decode.sv
// Turns the held mode into per-domain clock source selects and divider
// bypass bits. Assumes domains are ordered fastest first, so mode m puts
// domains 0..m on the at-speed clock.
module domain_sel_decode
    import scan_freq_pkg::*;
#(
    parameter int NUM_DOMAINS = 4,
    parameter int MODE_W      = 2
) (
    input  logic                     active_i,
    input  logic [MODE_W-1:0]        mode_i,
    output logic [2*NUM_DOMAINS-1:0] sel_o,
    output logic [NUM_DOMAINS-1:0]   bypass_o
);
    for (genvar d = 0; d < NUM_DOMAINS; d++) begin : g_dom
        localparam logic [MODE_W-1:0] D_IDX = MODE_W'(d);
        clk_src_e src;

        // Purpose: pick this domain's clock source from the nesting rule.
        always_comb begin
            if (!active_i)
                src = SRC_FUNC;
            else if (mode_i >= D_IDX)
                src = SRC_ATSPEED;
            else
                src = SRC_TESTER;
        end

        assign sel_o[2*d +: 2] = src;
        assign bypass_o[d]     = active_i;
    end
endmodule

// File: rtl/pll_sel_decode.sv
// Maps the held mode to a PLL frequency code: 0 is the functional rate and
// mode m uses code m+1, one step slower per added domain.
module pll_sel_decode
    import scan_freq_pkg::*;
#(
    parameter int MODE_W = 2,
    parameter int PLL_W  = 3
) (
    input  logic              active_i,
    input  logic [MODE_W-1:0] mode_i,
    output logic [PLL_W-1:0]  code_o
);
    // Purpose: choose the functional or the per-mode test rate code.
    always_comb begin
        if (active_i)
            code_o = PLL_W'(mode_i) + PLL_W'(1);
        else
            code_o = PLL_W'(PLL_CODE_FUNC);
    end
endmodule

// File: rtl/scan_freq_ctrl.sv
// Top of the scan frequency mode controller. Captures the mode, decodes the
// PLL code and the per-domain controls, and registers every output so that
// the clock mux selects come straight from flops.
module scan_freq_ctrl #(
    parameter  int NUM_DOMAINS = 4,
    localparam int MODE_W      = $clog2(NUM_DOMAINS),
    localparam int PLL_W       = $clog2(NUM_DOMAINS + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     test_en_i,
    input  logic [MODE_W-1:0]        mode_pins_i,
    output logic [PLL_W-1:0]         pll_sel_o,
    output logic [NUM_DOMAINS-1:0]   div_bypass_o,
    output logic [2*NUM_DOMAINS-1:0] clk_sel_o,
    output logic                     test_active_o,
    output logic [MODE_W-1:0]        mode_o
);
    logic                     active_q;
    logic [MODE_W-1:0]        mode_q;
    logic [2*NUM_DOMAINS-1:0] sel_d;
    logic [NUM_DOMAINS-1:0]   bypass_d;
    logic [PLL_W-1:0]         pll_d;

    scan_mode_capture #(.MODE_W(MODE_W)) cap_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .test_en_i   (test_en_i),
        .mode_pins_i (mode_pins_i),
        .active_o    (active_q),
        .mode_o      (mode_q)
    );

    domain_sel_decode #(.NUM_DOMAINS(NUM_DOMAINS), .MODE_W(MODE_W)) dom_i (
        .active_i (active_q),
        .mode_i   (mode_q),
        .sel_o    (sel_d),
        .bypass_o (bypass_d)
    );

    pll_sel_decode #(.MODE_W(MODE_W), .PLL_W(PLL_W)) pll_i (
        .active_i (active_q),
        .mode_i   (mode_q),
        .code_o   (pll_d)
    );

    // Purpose: glitch-free registered drive of all clock controls.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pll_sel_o     <= '0;
            div_bypass_o  <= '0;
            clk_sel_o     <= '0;
            test_active_o <= 1'b0;
            mode_o        <= '0;
        end else begin
            pll_sel_o     <= pll_d;
            div_bypass_o  <= bypass_d;
            clk_sel_o     <= sel_d;
            test_active_o <= active_q;
            mode_o        <= mode_q;
        end
    end
endmodule

// File: rtl/scan_freq_ctrl_chk.sv
// Checker for scan_freq_ctrl, bound to every instance of the top module.
// Assumes the select and PLL encodings of the brief.
module scan_freq_ctrl_chk #(
    parameter int NUM_DOMAINS = 4,
    parameter int MODE_W      = 2,
    parameter int PLL_W       = 3
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [PLL_W-1:0]         pll_sel_o,
    input logic [NUM_DOMAINS-1:0]   div_bypass_o,
    input logic [2*NUM_DOMAINS-1:0] clk_sel_o,
    input logic                     test_active_o,
    input logic [MODE_W-1:0]        mode_o
);
    logic [NUM_DOMAINS-1:0] fast_v;
    logic [NUM_DOMAINS-1:0] bad_v;

    // Purpose: flag, per domain, an at-speed select and an illegal code.
    always_comb begin
        for (int d = 0; d < NUM_DOMAINS; d++) begin
            fast_v[d] = (clk_sel_o[2*d +: 2] == 2'b01);
            bad_v[d]  = (clk_sel_o[2*d +: 2] == 2'b11);
        end
    end

    assert_no_illegal_sel_R4: assert property (@(posedge clk) disable iff (!rst_n)
        bad_v == '0);

    assert_mode_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (test_active_o && $past(test_active_o)) |-> ($stable(mode_o) && $stable(clk_sel_o)));

    assert_pll_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
        test_active_o |-> (pll_sel_o == PLL_W'(mode_o) + PLL_W'(1)));

    assert_bypass_all_R7: assert property (@(posedge clk) disable iff (!rst_n)
        test_active_o |-> (&div_bypass_o));

    assert_functional_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !test_active_o |-> (clk_sel_o == '0 && pll_sel_o == '0 && div_bypass_o == '0 && mode_o == '0));

    assert_fast_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
        test_active_o |-> ($countones(fast_v) == int'(mode_o) + 1));

    for (genvar d = 1; d < NUM_DOMAINS; d++) begin : g_nest
        assert_nested_R5: assert property (@(posedge clk) disable iff (!rst_n)
            fast_v[d] |-> fast_v[d-1]);
    end
endmodule

bind scan_freq_ctrl scan_freq_ctrl_chk #(
    .NUM_DOMAINS (NUM_DOMAINS),
    .MODE_W      (MODE_W),
    .PLL_W       (PLL_W)
) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .pll_sel_o     (pll_sel_o),
    .div_bypass_o  (div_bypass_o),
    .clk_sel_o     (clk_sel_o),
    .test_active_o (test_active_o),
    .mode_o        (mode_o)
);

// File: tb/scan_freq_ctrl_tb_top.sv
// Self-checking bench: a vector table walked per mode, then directed tests.
module scan_freq_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       test_en_i = 1'b0;
    logic [1:0] mode_pins_i = 2'b00;
    logic [2:0] pll_sel_o;
    logic [3:0] div_bypass_o;
    logic [7:0] clk_sel_o;
    logic       test_active_o;
    logic [1:0] mode_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    localparam logic [7:0] EXP_SEL [4] = '{8'hA9, 8'hA5, 8'h95, 8'h55};
    localparam logic [2:0] EXP_PLL [4] = '{3'd1, 3'd2, 3'd3, 3'd4};

    always #10 clk = ~clk;

    scan_freq_ctrl dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .test_en_i     (test_en_i),
        .mode_pins_i   (mode_pins_i),
        .pll_sel_o     (pll_sel_o),
        .div_bypass_o  (div_bypass_o),
        .clk_sel_o     (clk_sel_o),
        .test_active_o (test_active_o),
        .mode_o        (mode_o)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic check_func(input string req);
        check(req, "clk_sel", int'(clk_sel_o), 0);
        check(req, "pll_sel", int'(pll_sel_o), 0);
        check(req, "bypass", int'(div_bypass_o), 0);
        check(req, "active", int'(test_active_o), 0);
        check(req, "mode", int'(mode_o), 0);
    endtask

    task automatic edges(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        edges(3);
        check_func("R1");
        rst_n = 1'b1;
        edges(2);
        check_func("R1");

        for (int m = 0; m < 4; m++) begin
            test_en_i   = 1'b1;
            mode_pins_i = 2'(m);
            edges(1);
            check_func("R2");                       // R2 latency window
            edges(1);
            check("R5", "clk_sel", int'(clk_sel_o), int'(EXP_SEL[m]));
            check("R6", "pll_sel", int'(pll_sel_o), int'(EXP_PLL[m]));
            check("R7", "bypass", int'(div_bypass_o), 'hF);
            check("R9", "mode", int'(mode_o), m);
            check("R9", "active", int'(test_active_o), 1);
            mode_pins_i = ~2'(m);                   // R3 pins change mid pattern set
            edges(3);
            check("R3", "clk_sel", int'(clk_sel_o), int'(EXP_SEL[m]));
            check("R3", "pll_sel", int'(pll_sel_o), int'(EXP_PLL[m]));
            check("R3", "mode", int'(mode_o), m);
            test_en_i = 1'b0;
            edges(1);
            check("R8", "clk_sel still test", int'(clk_sel_o), int'(EXP_SEL[m]));
            edges(1);
            check_func("R8");
        end

        // R4: field layout with processor fast, all others on tester clock
        test_en_i   = 1'b1;
        mode_pins_i = 2'b00;
        edges(2);
        check("R4", "proc field", int'(clk_sel_o[1:0]), 1);
        check("R4", "periph field", int'(clk_sel_o[7:6]), 2);
        // R8 re-entry captures afresh
        test_en_i = 1'b0;
        edges(2);
        test_en_i   = 1'b1;
        mode_pins_i = 2'b10;
        edges(2);
        check("R8", "reentry sel", int'(clk_sel_o), 'h95);
        // R1 reset while active
        rst_n = 1'b0;
        edges(1);
        check_func("R1");
        rst_n     = 1'b1;
        test_en_i = 1'b0;
        edges(2);
        check_func("R1");

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int c = 0; c < 20000; c++) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule